// File: doc/BRIEF.md
# Resolver Carrier Reference Generator

This block produces the single sine excitation carrier shared by every resolver channel of a multi-channel resolver front end. A sine table, indexed by an 8-bit carrier phase, feeds a first-order sigma-delta modulator. The modulator emits a one-bit pulse-density stream on a complementary output pair, which an external low-pass filter and driver turn into the analog carrier. Because the carrier is global, one instance serves all channels.

The carrier period is a whole number of reference clocks: 5000, 10000 or 20000, roughly 10 kHz, 5 kHz and 2.5 kHz from a 50 MHz reference. A 2-bit select input picks the period, and a new choice is adopted only when the current carrier cycle ends. The period is split into 256 phase steps by a fractional accumulator, so every cycle holds exactly 256 steps of 19 or 20 clocks at the fastest rate. Downstream acquisition logic uses the phase count, a per-step strobe and a start-of-cycle strobe to sample sine and cosine in lockstep with the carrier.

All ports are plain control and status signals. The block has no data stream interface, so it has no valid/ready handshake and no back-pressure.

Top module: `carrier_ref_gen`

## Requirements
- R1: After reset the phase output is 0, both strobes are low, pdm_p is 0 and pdm_n is 1. The period is 5000 clocks, so the first cycle_start comes exactly 5000 clocks after reset is released.
- R2: freq_sel selects the period between consecutive cycle_start pulses: 2'b01 gives 20000 clocks, 2'b10 gives 10000 clocks and 2'b11 gives 5000 clocks.
- R3: freq_sel = 2'b00 is ignored, and the period in force is kept.
- R4: freq_sel is sampled only at a carrier cycle boundary. A cycle that is under way when freq_sel changes completes with its original length.
- R5: Every carrier cycle holds exactly 256 sub_tick pulses. The spacing between sub_ticks is floor(P/256) or ceil(P/256) clocks, where P is that cycle's period.
- R6: phase advances by exactly one, modulo 256, on each sub_tick and is otherwise constant. cycle_start is high exactly when phase has just wrapped to 0, and sub_tick is high in the same cycle.
- R7: pdm_n is the complement of pdm_p in every clock cycle.
- R8: Over one carrier cycle the pdm_p density is 50% within 2%. While phase is in 0..127 (positive half of the sine) the density is above 70%; while phase is in 128..255 it is below 30%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_sel | input | 2 | Carrier rate choice: 01 slow, 10 middle, 11 fast, 00 keep |
| pdm_p | output | 1 | Pulse-density carrier, true polarity |
| pdm_n | output | 1 | Pulse-density carrier, complement |
| phase | output | 8 | Carrier phase step, 0..255 |
| sub_tick | output | 1 | One-clock pulse on each phase step |
| cycle_start | output | 1 | One-clock pulse when phase returns to 0 |

## Verification
Every output is a register, so a phase step appears one clock after the edge on which the accumulator crosses the period. The first cycle_start after reset therefore lands on clock 5000, and a freq_sel change is seen only on the cycle that begins after the next cycle_start. The bench drives inputs and samples outputs on the falling clock edge, and counts falling edges between cycle_start pulses to obtain each cycle length. It keeps its own phase model, which advances on every observed sub_tick, and compares the phase output on every clock. PDM densities are accumulated over whole cycles, so the one-clock lag of the modulator register does not affect them.

// File: rtl/carrier_pkg.sv
package carrier_pkg;

  typedef enum logic [1:0] {
    SEL_KEEP = 2'b00,
    SEL_SLOW = 2'b01,
    SEL_MID  = 2'b10,
    SEL_FAST = 2'b11
  } rate_sel_e;

  // Integer half-sine approximation (rational form), t in [0, half)
  function automatic int half_sine(input int t, input int half, input int ampl);
    int q;
    q = t * (half - t);
    return (ampl * 16 * q) / (5 * half * half - 4 * q);
  endfunction

endpackage

// File: rtl/carrier_rate_sel.sv
module carrier_rate_sel
  import carrier_pkg::*;
#(
  parameter int DIV_FAST = 5000,
  parameter int DIV_MID  = 10000,
  parameter int DIV_SLOW = 20000,
  parameter int CNT_W    = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             wrap,
  output logic [CNT_W-1:0] period
);

  localparam logic [CNT_W-1:0] P_FAST = CNT_W'(DIV_FAST);
  localparam logic [CNT_W-1:0] P_MID  = CNT_W'(DIV_MID);
  localparam logic [CNT_W-1:0] P_SLOW = CNT_W'(DIV_SLOW);

  // R4: new selection adopted only at the cycle boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= P_FAST;
    end else if (wrap) begin
      unique case (rate_sel_e'(sel))
        SEL_SLOW: period <= P_SLOW;
        SEL_MID:  period <= P_MID;
        SEL_FAST: period <= P_FAST;
        SEL_KEEP: period <= period;   // R3: keep code ignored
        default:  period <= period;
      endcase
    end
  end

  a_r4_period_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(period));

  a_r2_period_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (period == P_FAST) || (period == P_MID) || (period == P_SLOW));

endmodule

// File: rtl/carrier_phase_gen.sv
module carrier_phase_gen #(
  parameter int PHASE_W = 8,
  parameter int CNT_W   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   period,
  output logic [PHASE_W-1:0] phase,
  output logic               sub_tick,
  output logic               cycle_start,
  output logic               wrap
);

  localparam int ACC_W = CNT_W + 1;
  localparam int STEPS = 1 << PHASE_W;
  localparam logic [ACC_W-1:0] STEP_INC = ACC_W'(STEPS);

  logic [ACC_W-1:0] frac_acc;
  logic [ACC_W-1:0] frac_sum;
  logic [ACC_W-1:0] period_x;
  logic             step;

  // Fractional divide: P clocks contain exactly STEPS steps (R5)
  always_comb begin
    period_x = {1'b0, period};
    frac_sum = frac_acc + STEP_INC;
    step     = (frac_sum >= period_x);
    wrap     = step && (phase == {PHASE_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_acc    <= '0;
      phase       <= '0;
      sub_tick    <= 1'b0;
      cycle_start <= 1'b0;
    end else begin
      if (wrap)      frac_acc <= '0;
      else if (step) frac_acc <= frac_sum - period_x;
      else           frac_acc <= frac_sum;
      if (step) phase <= phase + 1'b1;
      sub_tick    <= step;
      cycle_start <= wrap;
    end
  end

  a_r6_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (phase == '0) && sub_tick);

  a_r6_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    sub_tick |-> (phase == PHASE_W'($past(phase) + 1'b1)));

  a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_tick |-> $stable(phase));

  a_r5_acc_below_period: assert property (@(posedge clk) disable iff (!rst_n)
    frac_acc < period_x);

endmodule

// File: rtl/carrier_sine_lut.sv
module carrier_sine_lut
  import carrier_pkg::*;
#(
  parameter int PHASE_W  = 8,
  parameter int SAMPLE_W = 10,
  parameter int AMPL     = 500
) (
  input  logic [PHASE_W-1:0]  phase,
  output logic [SAMPLE_W-1:0] sample
);

  localparam int STEPS = 1 << PHASE_W;
  localparam int HALF  = STEPS / 2;
  localparam int MID   = 1 << (SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] table_q [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_entry
    localparam int MAG = half_sine(g % HALF, HALF, AMPL);
    localparam int VAL = (g < HALF) ? (MID + MAG) : (MID - MAG);
    assign table_q[g] = SAMPLE_W'(VAL);
  end

  assign sample = table_q[phase];

endmodule

// File: rtl/carrier_pdm_mod.sv
module carrier_pdm_mod #(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                pdm_p,
  output logic                pdm_n
);

  logic [SAMPLE_W-1:0] err_acc;
  logic [SAMPLE_W:0]   err_sum;

  assign err_sum = {1'b0, err_acc} + {1'b0, sample};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_acc <= '0;
      pdm_p   <= 1'b0;
      pdm_n   <= 1'b1;
    end else begin
      err_acc <= err_sum[SAMPLE_W-1:0];
      pdm_p   <= err_sum[SAMPLE_W];
      pdm_n   <= ~err_sum[SAMPLE_W];
    end
  end

  a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
    pdm_n == !pdm_p);

endmodule

// File: rtl/carrier_ref_gen.sv
module carrier_ref_gen #(
  parameter int DIV_FAST = 5000,
  parameter int DIV_MID  = 10000,
  parameter int DIV_SLOW = 20000,
  parameter int PHASE_W  = 8,
  parameter int SAMPLE_W = 10,
  parameter int AMPL     = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         freq_sel,
  output logic               pdm_p,
  output logic               pdm_n,
  output logic [PHASE_W-1:0] phase,
  output logic               sub_tick,
  output logic               cycle_start
);

  localparam int CNT_W = $clog2(DIV_SLOW + 1);

  logic [CNT_W-1:0]    period;
  logic                wrap;
  logic [SAMPLE_W-1:0] sample;

  carrier_rate_sel #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW), .CNT_W(CNT_W)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .sel(freq_sel), .wrap(wrap), .period(period)
  );

  carrier_phase_gen #(.PHASE_W(PHASE_W), .CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .period(period), .phase(phase),
    .sub_tick(sub_tick), .cycle_start(cycle_start), .wrap(wrap)
  );

  carrier_sine_lut #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .AMPL(AMPL)) u_lut (
    .phase(phase), .sample(sample)
  );

  carrier_pdm_mod #(.SAMPLE_W(SAMPLE_W)) u_pdm (
    .clk(clk), .rst_n(rst_n), .sample(sample), .pdm_p(pdm_p), .pdm_n(pdm_n)
  );

  a_r1_strobes_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !sub_tick && !cycle_start);

endmodule

// File: tb/carrier_ref_gen_tb.sv
module carrier_ref_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] freq_sel = 2'b00;
  logic       pdm_p, pdm_n, sub_tick, cycle_start;
  logic [7:0] phase;

  always #10 clk = ~clk;

  carrier_ref_gen u_dut (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .pdm_p(pdm_p), .pdm_n(pdm_n),
    .phase(phase), .sub_tick(sub_tick), .cycle_start(cycle_start)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // per-cycle measurements
  int len, ticks, ones_all, ones_lo, clk_lo, ones_hi, clk_hi, gap, gmin, gmax;
  int phase_bad, cmpl_bad, start_bad;
  logic [7:0] exp_phase = 8'd0;

  localparam int N_VEC = 6;
  localparam logic [1:0] SEL_V [N_VEC] = '{2'b01, 2'b11, 2'b00, 2'b10, 2'b00, 2'b11};
  localparam int         PER_V [N_VEC] = '{20000, 5000, 5000, 10000, 10000, 5000};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_meas();
    len = 0; ticks = 0; ones_all = 0; ones_lo = 0; clk_lo = 0; ones_hi = 0; clk_hi = 0;
    gmin = 1 << 30; gmax = 0; phase_bad = 0; cmpl_bad = 0; start_bad = 0;
  endtask

  task automatic step_clk();
    @(negedge clk);
    len++; gap++;
    if (pdm_n == pdm_p) cmpl_bad++;
    ones_all += int'(pdm_p);
    if (phase < 8'd128) begin clk_lo++; ones_lo += int'(pdm_p); end
    else                begin clk_hi++; ones_hi += int'(pdm_p); end
    if (sub_tick) begin
      ticks++;
      exp_phase = exp_phase + 8'd1;
      if (gap < gmin) gmin = gap;
      if (gap > gmax) gmax = gap;
      gap = 0;
    end
    if (phase != exp_phase) phase_bad++;
    if (cycle_start && !(sub_tick && phase == 8'd0)) start_bad++;
    if (!cycle_start && sub_tick && phase == 8'd0) start_bad++;
  endtask

  // Runs to the next cycle_start; changes freq_sel after sw_at clocks (if sw_at > 0)
  task automatic run_cycle(input int sw_at, input logic [1:0] sv);
    clear_meas();
    do begin
      step_clk();
      if (sw_at > 0 && len == sw_at) freq_sel = sv;
    end while (!cycle_start && len < 30000);
  endtask

  task automatic check_shape(input int per, input string tag);
    chk(ticks == 256, {tag, " R5 sub_tick count"}, ticks, 256);
    chk(gmin >= per / 256 && gmax <= (per + 255) / 256, {tag, " R5 spacing max"}, gmax, (per + 255) / 256);
    chk(phase_bad == 0, {tag, " R6 phase model mismatches"}, phase_bad, 0);
    chk(start_bad == 0, {tag, " R6 cycle_start alignment"}, start_bad, 0);
    chk(cmpl_bad == 0, {tag, " R7 complement mismatches"}, cmpl_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(phase == 8'd0, "R1 phase in reset", phase, 0);
    chk(!sub_tick && !cycle_start, "R1 strobes in reset", {sub_tick, cycle_start}, 0);
    chk(pdm_p == 1'b0 && pdm_n == 1'b1, "R1 pdm in reset", {pdm_p, pdm_n}, 1);
    rst_n = 1'b1;
    gap = 0;

    // R1/R5/R8: first cycle at default 5000 clocks
    run_cycle(0, 2'b00);
    chk(len == 5000, "R1 first cycle length", len, 5000);
    check_shape(5000, "default");
    chk(ones_all * 50 >= 5000 * 24 && ones_all * 50 <= 5000 * 26, "R8 cycle density", ones_all, 2500);
    chk(ones_lo * 10 > clk_lo * 7, "R8 positive half density", ones_lo, clk_lo * 7 / 10);
    chk(ones_hi * 10 < clk_hi * 3, "R8 negative half density", ones_hi, clk_hi * 3 / 10);

    // Table walk: R4 old length kept, then R2/R3 new length applies
    for (int i = 0; i < N_VEC; i++) begin
      int old_p;
      old_p = (i == 0) ? 5000 : PER_V[i-1];
      run_cycle(100, SEL_V[i]);
      chk(len == old_p, $sformatf("R4 vec%0d cycle under way keeps length", i), len, old_p);
      run_cycle(0, 2'b00);
      chk(len == PER_V[i], $sformatf("%s vec%0d new length", (SEL_V[i] == 2'b00) ? "R3" : "R2", i),
          len, PER_V[i]);
      check_shape(PER_V[i], $sformatf("vec%0d", i));
    end

    // R8 at the slow rate
    freq_sel = 2'b01;
    run_cycle(0, 2'b00);
    run_cycle(0, 2'b00);
    chk(len == 20000, "R2 slow length", len, 20000);
    chk(ones_all * 50 >= 20000 * 24 && ones_all * 50 <= 20000 * 26, "R8 slow cycle density", ones_all, 10000);
    chk(ones_lo * 10 > clk_lo * 7, "R8 slow positive half density", ones_lo, clk_lo * 7 / 10);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule